// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Time Copy

This block keeps a running calendar in packed BCD: century, year, month, day of month, weekday, hour (24-hour), minute and second. The live counters advance once per second. The second comes from a prescaler that counts `TICKS_PER_SEC` pulses of a tick enable input. When `TICKS_PER_SEC` is 1, the tick input acts directly as a one-pulse-per-second enable. Month lengths and leap years are handled inside the counters.

The host never sees the live counters. It sees a second copy of the time bytes through a small byte-wide register window. Reads are combinational on the address and writes are single-cycle. The copy is refreshed from the live counters as a whole, once per second. A control byte holds two freeze bits. The read-freeze bit holds the copy steady so that a multi-byte read is coherent. The load-freeze bit holds the copy so that the host can write a new time into it. Clearing the load-freeze bit commits the whole copy into the live counters and restarts the prescaler. A halt bit in the seconds byte suspends counting, and the host can change it at any time.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset, the control byte reads 0x00, the halt bit reads 0, and the time copy reads century 0x20, year 0x00, month 0x01, date 0x01, weekday 0x01, and 00:00:00.
- R2: The register window has these addresses. 0 is control (bit 7 load-freeze, bit 6 read-freeze). 1 is seconds (bit 7 halt, bits 6:0 BCD seconds). 2 is minutes. 3 is hours. 4 is weekday. 5 is date. 6 is month. 7 is year. 8 is century. Every other address reads 0x00. `rdata_o` follows `addr_i` without a clock.
- R3: The live time advances by one second on every `TICKS_PER_SEC`-th accepted tick pulse. The new value appears in the copy one clock after the edge that accepted the completing pulse.
- R4: Seconds and minutes wrap 59 to 00. Hours wrap 23 to 00 and step the date and the weekday. The weekday counts 1 to 7 and wraps to 1. The month wraps 12 to 01 and steps the year. The year wraps 99 to 00 and steps the century.
- R5: Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year value is divisible by 4 (00 included) and 28 days otherwise. All other months have 31 days.
- R6: While the read-freeze bit is 1, the copy does not change, and the live counters keep running. After the bit is cleared, the next completed second puts the live time into the copy.
- R7: A refresh that is already due in the cycle where the host sets a freeze bit still completes.
- R8: While the load-freeze bit is 1, the copy is not refreshed and writes to addresses 1 to 8 land in the copy. While the bit is 0, writes to addresses 2 to 8 and to bits 6:0 of address 1 have no effect.
- R9: Writing 0 to bit 7 of the control byte while it is 1 loads every copy byte into the live counters and clears the prescaler. The next advance then needs `TICKS_PER_SEC` more tick pulses.
- R10: Bit 7 of a write to address 1 sets the halt bit, whatever the state of the freeze bits. While the halt bit is 1, tick pulses are not accepted, and neither the prescaler nor the time moves.
- R11: Bits 5:0 of a control write are discarded and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick enable, one clock wide per pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |

## Verification
Control writes, time-byte writes and halt-bit writes are visible on `rdata_o` right after the edge that takes them. The address-to-data path is combinational. A completed second moves the live counters at the accepting edge, but the copy follows only one edge later. So a read between those two edges must still return the old time. The bench models the block one clock at a time, with exactly that one-edge gap between the live advance and the refresh. Every register is read after each clock step, just after the rising edge, with the address stepped in small delays so that all reads finish before the next falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hours;
    logic [7:0] mins;
    logic [7:0] secs;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{
    cent: 8'h20, year: 8'h00, month: 8'h01, mday: 8'h01,
    wday: 8'h01, hours: 8'h00, mins: 8'h00, secs: 8'h00
  };

  localparam int RA_CTRL = 0;
  localparam int RA_SEC  = 1;
  localparam int RA_MIN  = 2;
  localparam int RA_HOUR = 3;
  localparam int RA_WDAY = 4;
  localparam int RA_MDAY = 5;
  localparam int RA_MON  = 6;
  localparam int RA_YEAR = 7;
  localparam int RA_CENT = 8;

  localparam int BIT_WRITE = 7;
  localparam int BIT_READ  = 6;
  localparam int BIT_HALT  = 7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_mday(input logic [7:0] month, input logic [7:0] year);
    logic [6:0] ybin;
    ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    case (month)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      stop_i,
  input  logic      commit_i,
  input  rtc_time_t load_i,
  output rtc_time_t live_o,
  output logic      sec_stb_o,
  output logic      upd_o
);

  rtc_time_t live_q, live_nxt;
  logic      sec_stb;
  logic      upd_q;

  generate
    if (TICKS_PER_SEC > 1) begin : g_presc
      localparam int unsigned PS_W = $clog2(TICKS_PER_SEC);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICKS_PER_SEC - 1);
      logic [PS_W-1:0] ps_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 ps_q <= '0;
        else if (commit_i)           ps_q <= '0;
        else if (tick_i && !stop_i)  ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
      end

      assign sec_stb = tick_i && !stop_i && (ps_q == PS_LAST);
    end else begin : g_direct
      assign sec_stb = tick_i && !stop_i;
    end
  endgenerate

  // carry chain, one second forward
  always_comb begin
    live_nxt = live_q;
    if (live_q.secs != 8'h59) begin
      live_nxt.secs = bcd_inc(live_q.secs);
    end else begin
      live_nxt.secs = 8'h00;
      if (live_q.mins != 8'h59) begin
        live_nxt.mins = bcd_inc(live_q.mins);
      end else begin
        live_nxt.mins = 8'h00;
        if (live_q.hours != 8'h23) begin
          live_nxt.hours = bcd_inc(live_q.hours);
        end else begin
          live_nxt.hours = 8'h00;
          live_nxt.wday  = (live_q.wday == 8'h07) ? 8'h01 : bcd_inc(live_q.wday);
          if (live_q.mday != last_mday(live_q.month, live_q.year)) begin
            live_nxt.mday = bcd_inc(live_q.mday);
          end else begin
            live_nxt.mday = 8'h01;
            if (live_q.month != 8'h12) begin
              live_nxt.month = bcd_inc(live_q.month);
            end else begin
              live_nxt.month = 8'h01;
              if (live_q.year != 8'h99) begin
                live_nxt.year = bcd_inc(live_q.year);
              end else begin
                live_nxt.year = 8'h00;
                live_nxt.cent = (live_q.cent == 8'h99) ? 8'h00 : bcd_inc(live_q.cent);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= RESET_TIME;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= sec_stb && !commit_i;
      if (commit_i)     live_q <= load_i;
      else if (sec_stb) live_q <= live_nxt;
    end
  end

  assign live_o    = live_q;
  assign sec_stb_o = sec_stb;
  assign upd_o     = upd_q;

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         live_i,
  input  logic              upd_i,
  output rtc_time_t         shadow_o,
  output logic              rd_halt_o,
  output logic              wr_halt_o,
  output logic              stop_o,
  output logic              commit_o,
  output logic [7:0]        rdata_o
);

  rtc_time_t shadow_q;
  logic      rd_halt_q, wr_halt_q, stop_q;
  logic      wr_ctrl, wr_sec;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_W'(RA_CTRL));
  assign wr_sec   = wr_en_i && (addr_i == ADDR_W'(RA_SEC));
  assign commit_o = wr_ctrl && wr_halt_q && !wdata_i[BIT_WRITE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= RESET_TIME;
      rd_halt_q <= 1'b0;
      wr_halt_q <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        rd_halt_q <= wdata_i[BIT_READ];
        wr_halt_q <= wdata_i[BIT_WRITE];
      end
      if (wr_sec) stop_q <= wdata_i[BIT_HALT];
      // refresh uses the freeze bits held before this edge
      if (upd_i && !rd_halt_q && !wr_halt_q) begin
        shadow_q <= live_i;
      end else if (wr_en_i && wr_halt_q) begin
        case (int'(addr_i))
          RA_SEC:  shadow_q.secs  <= {1'b0, wdata_i[6:0]};
          RA_MIN:  shadow_q.mins  <= wdata_i;
          RA_HOUR: shadow_q.hours <= wdata_i;
          RA_WDAY: shadow_q.wday  <= wdata_i;
          RA_MDAY: shadow_q.mday  <= wdata_i;
          RA_MON:  shadow_q.month <= wdata_i;
          RA_YEAR: shadow_q.year  <= wdata_i;
          RA_CENT: shadow_q.cent  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (int'(addr_i))
      RA_CTRL: begin
        rdata_o[BIT_WRITE] = wr_halt_q;
        rdata_o[BIT_READ]  = rd_halt_q;
      end
      RA_SEC:  rdata_o = {stop_q, shadow_q.secs[6:0]};
      RA_MIN:  rdata_o = shadow_q.mins;
      RA_HOUR: rdata_o = shadow_q.hours;
      RA_WDAY: rdata_o = shadow_q.wday;
      RA_MDAY: rdata_o = shadow_q.mday;
      RA_MON:  rdata_o = shadow_q.month;
      RA_YEAR: rdata_o = shadow_q.year;
      RA_CENT: rdata_o = shadow_q.cent;
      default: rdata_o = 8'h00;
    endcase
  end

  assign shadow_o  = shadow_q;
  assign rd_halt_o = rd_halt_q;
  assign wr_halt_o = wr_halt_q;
  assign stop_o    = stop_q;

endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4,
  parameter int unsigned ADDR_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  rtc_time_t live_time, shadow_time;
  logic      rd_halt, wr_halt, stop, commit, sec_stb, upd;

  rtc_cal_core #(
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .stop_i   (stop),
    .commit_i (commit),
    .load_i   (shadow_time),
    .live_o   (live_time),
    .sec_stb_o(sec_stb),
    .upd_o    (upd)
  );

  rtc_shadow_regs #(
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .live_i   (live_time),
    .upd_i    (upd),
    .shadow_o (shadow_time),
    .rd_halt_o(rd_halt),
    .wr_halt_o(wr_halt),
    .stop_o   (stop),
    .commit_o (commit),
    .rdata_o  (rdata_o)
  );

endmodule

// File: rtl/rtc_shadow_clock_chk.sv
module rtc_shadow_clock_chk
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input rtc_time_t         live_time,
  input rtc_time_t         shadow_time,
  input logic              rd_halt,
  input logic              stop,
  input logic              commit,
  input logic              sec_stb
);

  // R2
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(RA_CENT)) |-> (rdata_o == 8'h00));

  // R11
  ctrl_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(RA_CTRL)) |-> (rdata_o[5:0] == 6'd0));

  // R3
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_stb && !commit) |=> $stable(live_time));

  // R6
  read_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_halt && !wr_en_i) |=> $stable(shadow_time));

  // R9
  commit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (live_time == $past(shadow_time)));

  // R10
  halt_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !commit) |=> $stable(live_time));

endmodule

bind rtc_shadow_clock rtc_shadow_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .live_time  (live_time),
  .shadow_time(shadow_time),
  .rd_halt    (rd_halt),
  .stop       (stop),
  .commit     (commit),
  .sec_stb    (sec_stb)
);

// File: tb/rtc_shadow_clock_test.sv
`timescale 1ns/10ps
module rtc_shadow_clock_test;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;
  localparam int AW         = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;

  int n_chk = 0;
  int n_bad = 0;

  // model: live time in binary, copy bytes by address, control state
  int L_cent, L_year, L_mon, L_date, L_wday, L_hour, L_min, L_sec;
  logic [7:0] sh [1:8];
  bit m_read, m_write, m_stop, m_pend;
  int m_ps;

  rtc_shadow_clock #(.TICKS_PER_SEC(TPS), .ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] b2bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int bcd2b(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    L_sec++;
    if (L_sec == 60) begin
      L_sec = 0; L_min++;
      if (L_min == 60) begin
        L_min = 0; L_hour++;
        if (L_hour == 24) begin
          L_hour = 0;
          L_wday = (L_wday == 7) ? 1 : L_wday + 1;
          if (L_date == mdays(L_mon, L_year)) begin
            L_date = 1; L_mon++;
            if (L_mon == 13) begin
              L_mon = 1; L_year++;
              if (L_year == 100) begin
                L_year = 0;
                L_cent = (L_cent == 99) ? 0 : L_cent + 1;
              end
            end
          end else L_date++;
        end
      end
    end
  endtask

  task automatic snapshot();
    sh[1] = b2bcd(L_sec); sh[2] = b2bcd(L_min); sh[3] = b2bcd(L_hour);
    sh[4] = b2bcd(L_wday); sh[5] = b2bcd(L_date); sh[6] = b2bcd(L_mon);
    sh[7] = b2bcd(L_year); sh[8] = b2bcd(L_cent);
  endtask

  task automatic model_reset();
    L_cent = 20; L_year = 0; L_mon = 1; L_date = 1; L_wday = 1;
    L_hour = 0; L_min = 0; L_sec = 0;
    snapshot();
    m_read = 0; m_write = 0; m_stop = 0; m_pend = 0; m_ps = 0;
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 0) return {m_write, m_read, 6'd0};
    if (a == 1) return {m_stop, sh[1][6:0]};
    if (a >= 2 && a <= 8) return sh[a];
    return 8'h00;
  endfunction

  // one clock: drive, take the edge, then step the model
  task automatic cycle(input bit wr, input int a, input logic [7:0] d, input bit tk);
    bit o_read, o_write, o_stop, n_pend;
    @(negedge clk_i);
    wr_en_i = wr; addr_i = AW'(a); wdata_i = d; tick_i = tk;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; tick_i = 1'b0;
    o_read = m_read; o_write = m_write; o_stop = m_stop; n_pend = 0;
    if (m_pend && !o_read && !o_write) snapshot();
    if (wr && a == 0 && o_write && !d[7]) begin
      L_sec = bcd2b({1'b0, sh[1][6:0]}); L_min = bcd2b(sh[2]); L_hour = bcd2b(sh[3]);
      L_wday = bcd2b(sh[4]); L_date = bcd2b(sh[5]); L_mon = bcd2b(sh[6]);
      L_year = bcd2b(sh[7]); L_cent = bcd2b(sh[8]);
      m_ps = 0;
    end else if (tk && !o_stop) begin
      if (m_ps == TPS - 1) begin m_ps = 0; advance(); n_pend = 1; end
      else m_ps++;
    end
    if (wr) begin
      if (a == 0) begin m_read = d[6]; m_write = d[7]; end
      if (a == 1) m_stop = d[7];
      if (o_write && a == 1) sh[1] = {1'b0, d[6:0]};
      if (o_write && a >= 2 && a <= 8) sh[a] = d;
    end
    m_pend = n_pend;
  endtask

  task automatic chk(input string tag, input int a, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %02h expected %02h", tag, a, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      addr_i = AW'(a);
      #0.2;
      chk(tag, a, rdata_o, exp_rd(a));
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 8'h00, 1);
  endtask

  task automatic one_second();
    ticks(TPS);
    cycle(0, 0, 8'h00, 0);
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int dt,
                          input int wd, input int h, input int mi, input int s);
    cycle(1, 0, 8'h80, 0);
    cycle(1, 1, b2bcd(s), 0);  cycle(1, 2, b2bcd(mi), 0);
    cycle(1, 3, b2bcd(h), 0);  cycle(1, 4, b2bcd(wd), 0);
    cycle(1, 5, b2bcd(dt), 0); cycle(1, 6, b2bcd(mo), 0);
    cycle(1, 7, b2bcd(y), 0);  cycle(1, 8, b2bcd(c), 0);
    cycle(1, 0, 8'h00, 0);
  endtask

  function automatic logic [7:0] rnd_field(input int a);
    case (a)
      1: return {1'($urandom_range(0, 3) == 0), 7'(b2bcd($urandom_range(0, 59)))};
      2: return b2bcd($urandom_range(0, 59));
      3: return b2bcd($urandom_range(0, 23));
      4: return b2bcd($urandom_range(1, 7));
      5: return b2bcd($urandom_range(1, 28));
      6: return b2bcd($urandom_range(1, 12));
      7: return b2bcd($urandom_range(0, 99));
      default: return b2bcd($urandom_range(19, 21));
    endcase
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7411);
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_all("R1");

    // R3: prescaler and one-edge refresh lag
    ticks(TPS - 1);
    check_all("R3 partial");
    ticks(1);
    check_all("R3 lag");
    cycle(0, 0, 8'h00, 0);
    check_all("R3 refresh");

    // R8 load and freeze, R9 commit with prescaler restart, R4/R5 leap day, weekday wrap
    cycle(1, 0, 8'h80, 0);
    cycle(1, 1, 8'h59, 0); cycle(1, 2, 8'h59, 0); cycle(1, 3, 8'h23, 0);
    cycle(1, 4, 8'h07, 0); cycle(1, 5, 8'h28, 0); cycle(1, 6, 8'h02, 0);
    cycle(1, 7, 8'h24, 0); cycle(1, 8, 8'h20, 0);
    check_all("R8 loaded");
    ticks(TPS + 2);
    cycle(0, 0, 8'h00, 0);
    check_all("R8 frozen");
    cycle(1, 0, 8'h00, 0);
    ticks(TPS - 1);
    cycle(0, 0, 8'h00, 0);
    check_all("R9 prescaler cleared");
    ticks(1);
    cycle(0, 0, 8'h00, 0);
    check_all("R5 R4 leap");

    set_time(20, 23, 2, 28, 3, 23, 59, 59); one_second(); check_all("R5 nonleap");
    set_time(20, 0, 2, 28, 1, 23, 59, 59);  one_second(); check_all("R5 year00");
    set_time(20, 25, 4, 30, 2, 23, 59, 59); one_second(); check_all("R5 april");
    set_time(20, 25, 1, 31, 5, 23, 59, 59); one_second(); check_all("R5 january");
    set_time(20, 99, 12, 31, 6, 23, 59, 59); one_second(); check_all("R4 century");
    set_time(20, 25, 6, 10, 4, 9, 59, 59);  one_second(); check_all("R4 hour");

    // R6 read freeze
    cycle(1, 0, 8'h40, 0);
    one_second(); one_second();
    check_all("R6 frozen");
    cycle(1, 0, 8'h00, 0);
    check_all("R6 cleared");
    one_second();
    check_all("R6 resumed");

    // R7 freeze set while a refresh is due
    ticks(TPS);
    cycle(1, 0, 8'h40, 0);
    check_all("R7");
    cycle(1, 0, 8'h00, 0);

    // R8 writes ignored without load freeze
    cycle(1, 2, 8'h33, 0); cycle(1, 7, 8'h11, 0); cycle(1, 1, 8'h45, 0);
    check_all("R8 ignored");

    // R10 halt
    cycle(1, 1, 8'h80, 0);
    check_all("R10 set");
    one_second(); one_second();
    check_all("R10 held");
    cycle(1, 1, 8'h00, 0);
    one_second();
    check_all("R10 released");

    // R11 reserved control bits
    cycle(1, 0, 8'h3F, 0);
    check_all("R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r < 10 || r > 17) cycle(0, 0, 8'h00, 1);
      else if (r < 12) cycle(0, 0, 8'h00, 0);
      else if (r < 14) cycle(1, 0, {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 6'($urandom)}, 0);
      else begin
        int a;
        a = $urandom_range(1, 8);
        cycle(1, a, rnd_field(a), 0);
      end
      check_all("R2 random");
    end

    report();
    $finish;
  end

endmodule